// File: doc/BRIEF.md
# Multi-Link Bank-Switch Synchronizer

This block is the common timing and trigger point for up to four audio bus links that must change configuration bank together. It runs a free sync counter whose period software programs, and it lets each link be armed for a coordinated bank switch. A single go write then causes every armed link to switch in the same clock cycle.

Software reaches the block through one 32-bit register port. The period field is staged first. It takes effect only when software also sets the update request bit, and it is loaded at the next counter wrap. Arm bits gather the links for the next switch. The go bit queues that switch. At the following sync boundary the block pulses one strobe per armed link, then clears the go bit. Software sees the go clear by polling.

Top module: `bank_sync_unit`

## Requirements
- R1: After reset the register reads 0, all strobes are low, the period-loaded pulse is low, and the active period is 0, so `sync_edge` is high every cycle.
- R2: Register layout on read: bits 14:0 hold the programmed period, bit 15 the update request, bits 19:16 the arm bits of links 0..3 (link i at bit 16+i), and bit 24 the go-pending flag. All other bits read 0.
- R3: The sync counter runs from 0 up to the active period and then wraps. `sync_edge` is high for the one cycle in which the counter equals the active period, so boundaries are active period + 1 cycles apart.
- R4: Writing bits 14:0 with bit 15 at 0 changes the programmed period shown on read, but not the active period.
- R5: Writing bit 15 as 1 sets the update request. At the next boundary the programmed period becomes active and the request clears. `period_loaded` is high for exactly the following cycle.
- R6: Writing 1 to bit 16+i arms link i. Writing 0 to an arm bit leaves it unchanged.
- R7: A write with bit 24 set, made while no go is pending and with at least one link armed (arm bits in the same write count), sets go-pending and clears all arm bits in the same edge.
- R8: In the cycle after the first boundary that follows an accepted go, `switch_strobe` equals the set of armed links for exactly one cycle, and go-pending clears.
- R9: A go write with no link armed has no effect: go-pending stays 0 and no strobe is produced.
- R10: Arm bits written while a go is pending stay armed for the following switch and are not part of the pending one.
- R11: A go write made while a go is already pending does not change the pending link set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write value |
| rd_data | output | 32 | Register read value |
| switch_strobe | output | 4 | One-cycle bank-switch pulse per link |
| sync_edge | output | 1 | High in the terminal-count cycle of the sync counter |
| period_loaded | output | 1 | One-cycle pulse after a new period became active |

## Verification
The trigger is driven with single-link, sparse, full and empty arm sets. This shows that each strobe lane follows only its own arm bit, and that an empty set is refused rather than pulsing nothing. A second go with fresh arms is written while a switch is still pending, which separates the pending set from the next one. Period changes with and without the update bit show that staging and activation are distinct, measured by the spacing between boundaries.

// File: rtl/bank_sync_unit.sv
module bank_sync_unit #(
  parameter int NLINK = 4,
  parameter int PER_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  output logic [31:0]      rd_data,
  output logic [NLINK-1:0] switch_strobe,
  output logic             sync_edge,
  output logic             period_loaded
);
  localparam int UPD_BIT = PER_W;
  localparam int ARM_LSB = 16;
  localparam int GO_BIT  = 24;

  logic [PER_W-1:0] per_prog, per_act, cnt;
  logic             upd_req, go_pend;
  logic [NLINK-1:0] arm, pend_mask;

  wire             boundary = (cnt == per_act);
  wire [NLINK-1:0] wr_arm   = wr_en ? wr_data[ARM_LSB +: NLINK] : '0;
  wire             go_take  = wr_en && wr_data[GO_BIT] && !go_pend && |(arm | wr_arm);

  assign sync_edge = boundary;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt           <= '0;
      per_prog      <= '0;
      per_act       <= '0;
      upd_req       <= 1'b0;
      go_pend       <= 1'b0;
      arm           <= '0;
      pend_mask     <= '0;
      switch_strobe <= '0;
      period_loaded <= 1'b0;
    end else begin
      cnt <= boundary ? '0 : cnt + 1'b1;
      if (wr_en) per_prog <= wr_data[PER_W-1:0];
      if (wr_en && wr_data[UPD_BIT]) upd_req <= 1'b1;
      else if (boundary)             upd_req <= 1'b0;
      period_loaded <= boundary && upd_req;
      if (boundary && upd_req) per_act <= per_prog;
      if (go_take) begin
        arm       <= '0;
        pend_mask <= arm | wr_arm;
        go_pend   <= 1'b1;
      end else begin
        arm <= arm | wr_arm;
      end
      if (boundary && go_pend) begin
        switch_strobe <= pend_mask;
        go_pend       <= 1'b0;
      end else begin
        switch_strobe <= '0;
      end
    end
  end

  always_comb begin
    rd_data                    = '0;
    rd_data[PER_W-1:0]         = per_prog;
    rd_data[UPD_BIT]           = upd_req;
    rd_data[ARM_LSB +: NLINK]  = arm;
    rd_data[GO_BIT]            = go_pend;
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= per_act);

  // R8
  strobe_after_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|switch_strobe) |-> ($past(go_pend) && $past(boundary) && !go_pend));

  // R5
  load_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_loaded |-> ($past(upd_req) && $past(boundary)));

  // R9
  go_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(go_pend) |-> ($past(wr_en) && $past(wr_data[GO_BIT]) && arm == '0));

  // R7
  pend_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_pend |-> (pend_mask != '0));
endmodule

// File: tb/bank_sync_unit_tb.sv
module bank_sync_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [3:0]  switch_strobe;
  logic        sync_edge, period_loaded;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_sync_unit u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .switch_strobe(switch_strobe),
    .sync_edge(sync_edge), .period_loaded(period_loaded)
  );

  typedef struct packed { logic [3:0] arm; logic [3:0] exp; } vec_t;
  localparam vec_t VECS [5] = '{
    '{arm: 4'h1, exp: 4'h1},
    '{arm: 4'hA, exp: 4'hA},
    '{arm: 4'hF, exp: 4'hF},
    '{arm: 4'h8, exp: 4'h8},
    '{arm: 4'h0, exp: 4'h0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic align();
    for (int i = 0; i < 64 && !sync_edge; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic expect_switch(input string req, input logic [3:0] exp);
    int n = 0;
    while (!sync_edge && n < 64) begin
      chk(req, {28'd0, switch_strobe}, 32'd0);
      @(negedge clk); n++;
    end
    @(negedge clk);
    chk(req, {28'd0, switch_strobe}, {28'd0, exp});
    @(negedge clk);
    chk(req, {28'd0, switch_strobe}, 32'd0);
  endtask

  task automatic spacing(input string req, input int per);
    int n = 0;
    align();
    while (!sync_edge && n < 64) begin @(negedge clk); n++; end
    chk(req, n, per);
  endtask

  task automatic wait_loaded(input string req);
    int n = 0;
    while (!period_loaded && n < 64) begin @(negedge clk); n++; end
    chk(req, {31'd0, period_loaded}, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 R2 reset state
    chk("R1", rd_data, 32'd0);
    chk("R1", {28'd0, switch_strobe}, 32'd0);
    chk("R1", {31'd0, period_loaded}, 32'd0);
    chk("R1", {31'd0, sync_edge}, 32'd1);

    // R5 request period 5
    wr(32'h0000_8005);
    chk("R5", rd_data, 32'h0000_8005);
    wait_loaded("R5");
    chk("R5", rd_data, 32'h0000_0005);
    @(negedge clk);
    chk("R5", {31'd0, period_loaded}, 32'd0);
    spacing("R3", 5);

    // R4 staged period without request
    wr(32'h0000_0003);
    chk("R4", rd_data, 32'h0000_0003);
    spacing("R4", 5);
    wr(32'h0000_0005);

    // R6 arm set, zero leaves bits
    wr(32'h0003_0005);
    chk("R6", rd_data, 32'h0003_0005);
    wr(32'h0001_0005);
    chk("R6", rd_data, 32'h0003_0005);
    align();
    wr(32'h0100_0005);
    chk("R7", rd_data, 32'h0100_0005);
    expect_switch("R8", 4'h3);
    chk("R8", rd_data, 32'h0000_0005);

    // R8 R9 vector table
    foreach (VECS[k]) begin
      align();
      wr(32'h0100_0005 | ({28'd0, VECS[k].arm} << 16));
      if (VECS[k].arm != 4'h0) chk("R7", rd_data, 32'h0100_0005);
      else                     chk("R9", rd_data, 32'h0000_0005);
      expect_switch(VECS[k].arm != 4'h0 ? "R8" : "R9", VECS[k].exp);
      chk("R8", rd_data, 32'h0000_0005);
    end

    // R10 R11 arms during pending
    align();
    wr(32'h0103_0005);
    wr(32'h0104_0005);
    chk("R10", rd_data, 32'h0104_0005);
    expect_switch("R11", 4'h3);
    chk("R10", rd_data, 32'h0004_0005);
    align();
    wr(32'h0100_0005);
    expect_switch("R10", 4'h4);

    // R5 shorter period
    wr(32'h0000_8003);
    chk("R5", rd_data, 32'h0000_8003);
    wait_loaded("R5");
    chk("R5", rd_data, 32'h0000_0003);
    spacing("R3", 3);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule